// File: doc/BRIEF.md
# Reset-Hold Duration Meter

This block measures how long an active-low board reset input stays asserted. The input is first brought into the reference-clock domain. A counter then advances by one on every reference-clock cycle while the input is low. At full scale it stops instead of wrapping. The measured pin never resets the counter. Only a separate power-on reset does, so the value survives the reset it measured. Once the system is running again, firmware reads the value.

A two-word read/write strobe interface gives access to the block. Word 0 returns the measured count, and a write to word 0 with the top bit set clears it. Word 1 holds a seconds threshold and an enable bit. A combinational comparator raises `long_press` when the stored count reaches the threshold converted to clock ticks. Firmware can use this to trigger a factory-restore action after a long button press.

Top module: `rsthold_meter`

## Requirements
- R1: While the synchronised reset input is low, the count rises by exactly one per reference-clock cycle; holding the pin low for N cycles adds N to the count.
- R2: The count stops at its all-ones value (2^CNT_W - 1) and stays there while the pin remains low.
- R3: Releasing the pin leaves the count unchanged. Only `por_n` resets the block.
- R4: A write to word 0 (`addr`=0) with bit 31 set clears the count to zero. A write to word 0 with bit 31 clear has no effect on the count.
- R5: A read of word 0 returns the count in bits CNT_W-1:0, and all higher bits read as zero.
- R6: A new low period that follows a clear counts from zero. A new low period without a clear continues from the held value.
- R7: When a clear write and a counting cycle fall on the same edge, the clear wins and the count is zero after that edge.
- R8: Word 1 (`addr`=1) stores seconds in bits SEC_W-1:0 and the enable flag in bit SEC_W (bit 5 by default). A read of word 1 returns exactly these bits, with all higher bits zero.
- R9: `long_press` is high when the enable flag is set and the count is greater than or equal to TICKS_PER_SEC times the stored seconds. It follows the stored count with no register delay.
- R10: With the enable flag clear, `long_press` stays low whatever the count.
- R11: After `por_n`, the count is zero, word 1 reads zero and `long_press` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (25 MHz by default) |
| por_n | input | 1 | Active-low power-on reset for all block state |
| rst_pin_n | input | 1 | Asynchronous active-low reset input being timed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 1 | Word select: 0 count, 1 threshold |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected word, combinational |
| long_press | output | 1 | Count has reached the enabled threshold |

## Verification
The bench runs the counter into saturation. A design that wraps instead would read back a small value rather than all ones. It issues a clear on the same edge that would count, then releases the pin. Here a design that lets the increment win would read about thirty counts instead of two. It checks that a second low period resumes from the held value, and that a write without the clear bit leaves the count alone. A design that treats every write as a clear, or that restarts at each falling edge, fails those checks. Finally, it steps the count across the threshold one tick at a time, with the enable flag on and then off. This catches an off-by-one compare or a flag that ignores enable.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned CLR_BIT = 31;
   typedef enum logic {
      WORD_COUNT  = 1'b0,
      WORD_THRESH = 1'b1
   } word_sel_e;
endpackage

// File: rtl/rhm_sync.sv
module rhm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rhm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rhm_counter.sv
module rhm_counter #(
   parameter int unsigned CNT_W = 29
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             active,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                          cnt_q <= '0;
      else if (clear)                      cnt_q <= '0;
      else if (active && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!por_n)
      (active && !clear && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (!active && !clear) |=> $stable(cnt_q)); // R3
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!por_n)
      clear |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/rhm_thresh.sv
module rhm_thresh #(
   parameter int unsigned CNT_W         = 29,
   parameter int unsigned SEC_W         = 5,
   parameter int unsigned TICKS_PER_SEC = 25_000_000
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic [SEC_W:0]   load_val,
   input  logic [CNT_W-1:0] count,
   output logic [SEC_W:0]   cfg,
   output logic             hit
);
   localparam int unsigned PROD_W = 64;

   logic [SEC_W-1:0] secs_q;
   logic             en_q;
   logic [PROD_W-1:0] limit;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         secs_q <= '0;
         en_q   <= 1'b0;
      end else if (load) begin
         secs_q <= load_val[SEC_W-1:0];
         en_q   <= load_val[SEC_W];
      end
   end

   assign limit = PROD_W'(TICKS_PER_SEC) * PROD_W'(secs_q);
   assign hit   = en_q && (PROD_W'(count) >= limit);
   assign cfg   = {en_q, secs_q};

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!por_n)
      load |=> (cfg == $past(load_val))); // R8
endmodule

// File: rtl/rsthold_meter.sv
module rsthold_meter #(
   parameter int unsigned CNT_W         = 29,
   parameter int unsigned SEC_W         = 5,
   parameter int unsigned TICKS_PER_SEC = 25_000_000,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_pin_n,
   input  logic        wr_en,
   input  logic        addr,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic        long_press
);
   import rhm_pkg::*;

   generate
      if (CNT_W < 1 || CNT_W > CLR_BIT) begin : g_bad_cnt
         $error("rsthold_meter: CNT_W must be 1..31");
      end
      if (SEC_W < 1 || SEC_W + 1 > REG_W) begin : g_bad_sec
         $error("rsthold_meter: SEC_W out of range");
      end
      if (TICKS_PER_SEC < 1) begin : g_bad_ticks
         $error("rsthold_meter: TICKS_PER_SEC must be nonzero");
      end
   endgenerate

   logic             pin_sync_n;
   logic             do_clear;
   logic             do_load;
   logic [CNT_W-1:0] count;
   logic [SEC_W:0]   cfg;

   assign do_clear = wr_en && (word_sel_e'(addr) == WORD_COUNT) && wr_data[CLR_BIT];
   assign do_load  = wr_en && (word_sel_e'(addr) == WORD_THRESH);

   rhm_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .por_n    (por_n),
      .async_in (rst_pin_n),
      .sync_out (pin_sync_n)
   );

   rhm_counter #(.CNT_W(CNT_W)) i_counter (
      .clk    (clk),
      .por_n  (por_n),
      .active (!pin_sync_n),
      .clear  (do_clear),
      .count  (count)
   );

   rhm_thresh #(
      .CNT_W         (CNT_W),
      .SEC_W         (SEC_W),
      .TICKS_PER_SEC (TICKS_PER_SEC)
   ) i_thresh (
      .clk      (clk),
      .por_n    (por_n),
      .load     (do_load),
      .load_val (wr_data[SEC_W:0]),
      .count    (count),
      .cfg      (cfg),
      .hit      (long_press)
   );

   always_comb begin
      rd_data = '0;
      if (word_sel_e'(addr) == WORD_COUNT) rd_data[CNT_W-1:0] = count;
      else                                 rd_data[SEC_W:0]   = cfg;
   end

   AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      do_clear |=> (rd_data[CNT_W-1:0] == '0 || addr)); // R4
   AST_WRITE_NO_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && !addr && !wr_data[CLR_BIT] && pin_sync_n) |=> $stable(count)); // R4
endmodule

// File: tb/test_rsthold_meter.sv
module test_rsthold_meter;
   localparam int unsigned CW  = 8;
   localparam int unsigned SW  = 5;
   localparam int unsigned TPS = 10;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_pin_n = 1'b1;
   logic        wr_en = 1'b0;
   logic        addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        long_press;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   typedef struct {
      bit          is_flag;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t exp_q[$];
   event  sample_ev;

   always #4 clk = ~clk;

   rsthold_meter #(.CNT_W(CW), .SEC_W(SW), .TICKS_PER_SEC(TPS)) i_rsthold_meter (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .long_press(long_press)
   );

   // monitor: pop expected item and compare against the port
   initial begin
      forever begin
         @(sample_ev);
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = it.is_flag ? {31'b0, long_press} : rd_data;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_word(input logic a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      exp_q.push_back('{1'b0, e, tag});
      ->sample_ev;
      #1;
   endtask

   task automatic expect_flag(input bit e, input string tag);
      @(negedge clk);
      #1;
      exp_q.push_back('{1'b1, {31'b0, e}, tag});
      ->sample_ev;
      #1;
   endtask

   task automatic write_word(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   // hold the pin low for n reference cycles, then let the synchroniser drain
   task automatic hold_low(input int n);
      @(negedge clk);
      rst_pin_n = 1'b0;
      repeat (n) @(negedge clk);
      rst_pin_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (2) @(negedge clk);

      expect_word(0, 32'd0, "R11 count after reset");
      expect_word(1, 32'd0, "R11 threshold after reset");
      expect_flag(0, "R11 flag after reset");

      hold_low(20);
      expect_word(0, 32'd20, "R1 twenty cycles low");
      repeat (10) @(negedge clk);
      expect_word(0, 32'd20, "R3 value held after release");

      hold_low(15);
      expect_word(0, 32'd35, "R6 resume without clear");

      write_word(0, 32'h7FFF_FFFF);
      expect_word(0, 32'd35, "R4 write without clear bit ignored");

      write_word(0, 32'h8000_0000);
      expect_word(0, 32'd0, "R4 clear bit zeroes count");

      hold_low(7);
      expect_word(0, 32'd7, "R6 after clear counts from zero");

      hold_low(300);
      expect_word(0, 32'd255, "R2 saturates at all ones");
      hold_low(5);
      expect_word(0, 32'd255, "R5 upper bits zero at full scale");

      // R7: clear issued while counting, pin released right after
      write_word(0, 32'h8000_0000);
      @(negedge clk);
      rst_pin_n = 1'b0;
      repeat (30) @(negedge clk);
      wr_en = 1'b1; addr = 1'b0; wr_data = 32'h8000_0000;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; rst_pin_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_word(0, 32'd2, "R7 clear wins over count");

      // threshold: 2 s enabled => 20 ticks
      write_word(1, 32'hFFFF_FFE2);
      expect_word(1, 32'h0000_0022, "R8 threshold readback");
      write_word(0, 32'h8000_0000);
      hold_low(19);
      expect_flag(0, "R9 one tick below threshold");
      hold_low(1);
      expect_word(0, 32'd20, "R9 count at threshold");
      expect_flag(1, "R9 flag at threshold");

      write_word(1, 32'h0000_0002);
      expect_flag(0, "R10 disabled threshold");
      write_word(1, 32'h0000_0022);
      expect_flag(1, "R9 re-enabled threshold");
      write_word(0, 32'h8000_0000);
      expect_flag(0, "R9 flag drops with clear");

      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule